// File: doc/BRIEF.md
# LUT-Driven Nine-Point Pixel Remapper

This block builds one lens-corrected output frame. It visits every output pixel in raster order. For each pixel it reads one 32-bit remap word from a table memory. The word names a source location on a grid of actual pixels and half-pixel points, so there are nine candidate points around each actual pixel.

The block then reads one, two or four RGB565 pixels from an interlaced source frame buffer. It averages them per colour channel using only adders and right shifts. Each result goes out on a pixel stream with a valid/ready handshake. A reserved table value marks output pixels that have no source coverage, and these are emitted as black.

A one-cycle start pulse latches the table base, the two field base addresses and the source line width, then walks the whole frame. A one-cycle done pulse marks the end of the frame. Both memory ports use a request pulse that carries an address; the memory answers with a response-valid pulse and data after a fixed delay.

Top module: `pixel_remapper`

## Requirements
- R1: The remap word for output pixel (x, y) is read at word address table_base + y*OUT_W + x, and the words are read in raster order (x fastest). Word layout: bits 31..3 hold the source index, bit 2 selects the field (0 even, 1 odd), bit 1 flags a half step in x, and bit 0 flags a half step in y.
- R2: With neither half flag set, exactly one source read is made at field_base + index, and the pixel read is emitted unchanged. field_base is the even base when bit 2 is 0 and the odd base when bit 2 is 1.
- R3: With only the x flag set, pixels at index and index+1 of the same field are read. Each channel (red 15..11, green 10..5, blue 4..0) is output as its two-value sum shifted right by 1.
- R4: With only the y flag set, the base pixel and its lower neighbour are averaged as in R3. For an even-field word the lower neighbour is at odd_base + index. For an odd-field word it is at even_base + index + line_width.
- R5: With both flags set, four pixels are read: the base, its x neighbour, its y neighbour (per R4) and that neighbour's x neighbour. Each channel is output as its four-value sum shifted right by 2.
- R6: A word whose index field is all ones outputs 0x0000 and causes no source read.
- R7: Once pix_valid is high it stays high, with pix_data unchanged, until pix_ready is sampled high.
- R8: done is high for exactly one cycle, after the last pixel of the frame has been accepted, and never earlier in the frame.
- R9: Base addresses and line width are taken only at start. Changing those inputs during a frame has no effect on its addresses or pixels.
- R10: After reset, pix_valid, done, lut_req and src_req are low.
- R11: At most one memory request is outstanding at any time. No request is made in the cycle after another request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame; latches the configuration inputs |
| lut_base | input | ADDR_W | Word address of the first remap word |
| even_base | input | ADDR_W | Pixel address of the even field |
| odd_base | input | ADDR_W | Pixel address of the odd field |
| line_width | input | 29 | Source pixels per line |
| lut_req | output | 1 | Table read request pulse |
| lut_addr | output | ADDR_W | Table read address |
| lut_rvalid | input | 1 | Table response valid |
| lut_rdata | input | 32 | Table response word |
| src_req | output | 1 | Source read request pulse |
| src_addr | output | ADDR_W | Source pixel address |
| src_rvalid | input | 1 | Source response valid |
| src_rdata | input | 16 | Source RGB565 pixel |
| pix_valid | output | 1 | Output pixel valid |
| pix_data | output | 16 | Output RGB565 pixel |
| pix_ready | input | 1 | Downstream accepts the pixel |
| done | output | 1 | Frame-complete pulse |

## Verification
A wrong step counter or a wrong field-swap decision shows up on the next source request as a wrong src_addr. It also shows up on pix_data when that pixel is accepted, within six memory round trips.

A raster counter that skips or repeats a position shows up as a wrong lut_addr on the following table request. It also shows up as a done pulse that arrives early or late.

A lost or doubled accumulation shows up as a wrong channel average on the pixel being built. Bad handshake state shows up as pix_data changing while the pixel is stalled.

// File: rtl/remap_pkg.sv
package remap_pkg;

    localparam int ENTRY_W = 32;
    localparam int IDX_W   = 29;
    localparam int PIX_W   = 16;

    typedef struct packed {
        logic [4:0] r;
        logic [5:0] g;
        logic [4:0] b;
    } rgb565_t;

    typedef struct packed {
        logic [6:0] r;
        logic [7:0] g;
        logic [6:0] b;
    } rgb_sum_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             odd;
        logic             hx;
        logic             hy;
    } entry_t;

    typedef enum logic [2:0] {
        S_IDLE, S_LREQ, S_LWAIT, S_SREQ, S_SWAIT, S_OUT, S_DONE
    } state_t;

    function automatic logic entry_invalid(entry_t e);
        return &e.idx;
    endfunction

    function automatic rgb_sum_t sum_add(rgb_sum_t s, rgb565_t p);
        rgb_sum_t n;
        n.r = s.r + {2'b00, p.r};
        n.g = s.g + {2'b00, p.g};
        n.b = s.b + {2'b00, p.b};
        return n;
    endfunction

    function automatic rgb565_t sum_shift(rgb_sum_t s, logic [1:0] sh);
        rgb565_t  o;
        logic [6:0] tr, tb;
        logic [7:0] tg;
        tr = s.r >> sh;
        tg = s.g >> sh;
        tb = s.b >> sh;
        o.r = tr[4:0];
        o.g = tg[5:0];
        o.b = tb[4:0];
        return o;
    endfunction

endpackage

// File: rtl/remap_raster.sv
module remap_raster #(
    parameter int W      = 800,
    parameter int H      = 480,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              advance,
    output logic [ADDR_W-1:0] lin_idx,
    output logic              last
);
    localparam int XW = (W > 1) ? $clog2(W) : 1;
    localparam int YW = (H > 1) ? $clog2(H) : 1;

    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;

    assign last = (x_q == XW'(W-1)) && (y_q == YW'(H-1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            x_q     <= '0;
            y_q     <= '0;
            lin_idx <= '0;
        end else if (advance && !last) begin
            lin_idx <= lin_idx + 1'b1;
            if (x_q == XW'(W-1)) begin
                x_q <= '0;
                y_q <= y_q + 1'b1;
            end else begin
                x_q <= x_q + 1'b1;
            end
        end
    end

    // R1: raster position stays inside the output frame
    a_r1_in_frame: assert property (@(posedge clk) disable iff (rst)
        (x_q <= XW'(W-1)) && (y_q <= YW'(H-1)));

endmodule

// File: rtl/remap_addr_gen.sv
module remap_addr_gen
    import remap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  entry_t            entry,
    input  logic [1:0]        step,
    input  logic [ADDR_W-1:0] even_base,
    input  logic [ADDR_W-1:0] odd_base,
    input  logic [IDX_W-1:0]  line_w,
    output logic [ADDR_W-1:0] addr,
    output logic              last_step,
    output logic [1:0]        shamt
);
    logic dx, dy, use_odd;
    logic [ADDR_W-1:0] row_add;

    always_comb begin
        dx        = entry.hx & step[0];
        dy        = entry.hy & (entry.hx ? step[1] : step[0]);
        use_odd   = entry.odd ^ dy;
        row_add   = (dy && entry.odd) ? ADDR_W'(line_w) : '0;
        addr      = (use_odd ? odd_base : even_base) + ADDR_W'(entry.idx)
                  + ADDR_W'(dx) + row_add;
        last_step = (step == {entry.hx & entry.hy, entry.hx | entry.hy});
        shamt     = {1'b0, entry.hx} + {1'b0, entry.hy};
    end

endmodule

// File: rtl/remap_accum.sv
module remap_accum
    import remap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       add,
    input  rgb565_t    pix,
    input  logic [1:0] shamt,
    output rgb565_t    avg
);
    rgb_sum_t sum_q;

    always_ff @(posedge clk) begin
        if (rst || clear) sum_q <= '0;
        else if (add)     sum_q <= sum_add(sum_q, pix);
    end

    assign avg = sum_shift(sum_q, shamt);

    // R5: a four-term sum never exceeds four full-scale channels
    a_r5_sum_range: assert property (@(posedge clk) disable iff (rst)
        (sum_q.r <= 7'd124) && (sum_q.g <= 8'd252) && (sum_q.b <= 7'd124));

endmodule

// File: rtl/pixel_remapper.sv
module pixel_remapper
    import remap_pkg::*;
#(
    parameter int OUT_W  = 800,
    parameter int OUT_H  = 480,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] lut_base,
    input  logic [ADDR_W-1:0] even_base,
    input  logic [ADDR_W-1:0] odd_base,
    input  logic [28:0]       line_width,
    output logic              lut_req,
    output logic [ADDR_W-1:0] lut_addr,
    input  logic              lut_rvalid,
    input  logic [31:0]       lut_rdata,
    output logic              src_req,
    output logic [ADDR_W-1:0] src_addr,
    input  logic              src_rvalid,
    input  logic [15:0]       src_rdata,
    output logic              pix_valid,
    output logic [15:0]       pix_data,
    input  logic              pix_ready,
    output logic              done
);
    state_t            state;
    logic [ADDR_W-1:0] lut_base_q, even_q, odd_q;
    logic [IDX_W-1:0]  lw_q;
    entry_t            entry_q;
    logic [1:0]        step_q;
    logic [ADDR_W-1:0] lin_idx;
    logic              last_px, last_step;
    logic [1:0]        shamt;
    rgb565_t           avg;
    logic              acc_clear, acc_add, accept;

    assign accept    = (state == S_OUT) && pix_ready;
    assign acc_clear = (state == S_LWAIT) && lut_rvalid;
    assign acc_add   = (state == S_SWAIT) && src_rvalid;

    remap_raster #(.W(OUT_W), .H(OUT_H), .ADDR_W(ADDR_W)) u_raster (
        .clk(clk), .rst(rst),
        .clear((state == S_IDLE) && start),
        .advance(accept),
        .lin_idx(lin_idx), .last(last_px)
    );

    remap_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .entry(entry_q), .step(step_q),
        .even_base(even_q), .odd_base(odd_q), .line_w(lw_q),
        .addr(src_addr), .last_step(last_step), .shamt(shamt)
    );

    remap_accum u_accum (
        .clk(clk), .rst(rst), .clear(acc_clear), .add(acc_add),
        .pix(rgb565_t'(src_rdata)), .shamt(shamt), .avg(avg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            lut_base_q <= '0;
            even_q     <= '0;
            odd_q      <= '0;
            lw_q       <= '0;
            entry_q    <= '0;
            step_q     <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    lut_base_q <= lut_base;
                    even_q     <= even_base;
                    odd_q      <= odd_base;
                    lw_q       <= line_width;
                    state      <= S_LREQ;
                end
                S_LREQ: state <= S_LWAIT;
                S_LWAIT: if (lut_rvalid) begin
                    entry_q <= entry_t'(lut_rdata);
                    step_q  <= '0;
                    state   <= entry_invalid(entry_t'(lut_rdata)) ? S_OUT : S_SREQ;
                end
                S_SREQ: state <= S_SWAIT;
                S_SWAIT: if (src_rvalid) begin
                    if (last_step) state <= S_OUT;
                    else begin
                        step_q <= step_q + 1'b1;
                        state  <= S_SREQ;
                    end
                end
                S_OUT: if (pix_ready) state <= last_px ? S_DONE : S_LREQ;
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign lut_req   = (state == S_LREQ);
    assign lut_addr  = lut_base_q + lin_idx;
    assign src_req   = (state == S_SREQ);
    assign pix_valid = (state == S_OUT);
    assign pix_data  = entry_invalid(entry_q) ? 16'h0000 : 16'(avg);
    assign done      = (state == S_DONE);

    // R7: a stalled pixel stays valid and unchanged
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_data));
    // R11: the two memory ports never request together
    a_r11_one_port: assert property (@(posedge clk) disable iff (rst)
        !(lut_req && src_req));
    // R11: no back-to-back requests
    a_r11_no_burst: assert property (@(posedge clk) disable iff (rst)
        (lut_req || src_req) |=> !(lut_req || src_req));
    // R8: done is a single-cycle pulse with no pixel alongside
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !pix_valid);
    // R6: an invalid word never triggers a source read
    a_r6_no_read: assert property (@(posedge clk) disable iff (rst)
        (state == S_LWAIT) && lut_rvalid && (&lut_rdata[31:3]) |=> !src_req);

endmodule

// File: tb/pixel_remapper_bench.sv
module pixel_remapper_bench;
    localparam int OUT_W = 4;
    localparam int OUT_H = 3;
    localparam int NPIX  = OUT_W * OUT_H;
    localparam int LAT   = 2;
    localparam logic [28:0] INV = '1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] lut_base = '0, even_base = '0, odd_base = '0;
    logic [28:0] line_width = '0;
    logic        lut_req, src_req, lut_rvalid, src_rvalid;
    logic [31:0] lut_addr, src_addr, lut_rdata;
    logic [15:0] src_rdata, pix_data;
    logic        pix_valid, done;
    logic        pix_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [31:0] lut_mem [NPIX];
    logic [31:0] cur_lb;

    always #10 clk = ~clk;

    pixel_remapper #(.OUT_W(OUT_W), .OUT_H(OUT_H), .ADDR_W(32)) u_pixel_remapper (
        .clk(clk), .rst(rst), .start(start),
        .lut_base(lut_base), .even_base(even_base), .odd_base(odd_base),
        .line_width(line_width),
        .lut_req(lut_req), .lut_addr(lut_addr), .lut_rvalid(lut_rvalid), .lut_rdata(lut_rdata),
        .src_req(src_req), .src_addr(src_addr), .src_rvalid(src_rvalid), .src_rdata(src_rdata),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready), .done(done)
    );

    function automatic logic [15:0] src_val(logic [31:0] a);
        logic [15:0] m;
        m = a[15:0] * 16'd40503;
        return m ^ 16'h3C5A;
    endfunction

    // fixed-latency memory models
    logic [LAT-1:0] lv, sv;
    logic [31:0]    la [LAT];
    logic [31:0]    sa [LAT];
    always @(posedge clk) begin
        if (rst) begin
            lv <= '0;
            sv <= '0;
        end else begin
            lv <= {lv[LAT-2:0], lut_req};
            sv <= {sv[LAT-2:0], src_req};
        end
        la[0] <= lut_addr;
        sa[0] <= src_addr;
        for (int i = 1; i < LAT; i++) begin
            la[i] <= la[i-1];
            sa[i] <= sa[i-1];
        end
    end
    assign lut_rvalid = lv[LAT-1];
    assign src_rvalid = sv[LAT-1];
    assign src_rdata  = src_val(sa[LAT-1]);
    always_comb begin
        logic [31:0] off;
        off = la[LAT-1] - cur_lb;
        lut_rdata = (off < NPIX) ? lut_mem[off] : 32'h0;
    end

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int idx, bit fld, bit hx, bit hy);
        return {29'(idx), fld, hx, hy};
    endfunction

    function automatic string tag_of(logic [31:0] e);
        if (e[31:3] == INV) return "R6";
        case (e[1:0])
            2'b00: return "R2";
            2'b10: return "R3";
            2'b01: return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic int nreads(logic [31:0] e);
        if (e[31:3] == INV) return 0;
        return (e[1] ? 2 : 1) * (e[0] ? 2 : 1);
    endfunction

    function automatic logic [15:0] exp_pix(logic [31:0] e, logic [31:0] eb,
                                            logic [31:0] ob, logic [31:0] lw);
        logic [31:0] p00, p10, p01, p11, idx;
        logic [15:0] v [4];
        int r, g, b;
        idx = {3'b000, e[31:3]};
        if (e[31:3] == INV) return 16'h0000;
        p00 = (e[2] ? ob : eb) + idx;
        p10 = p00 + 1;
        p01 = e[2] ? (eb + idx + lw) : (ob + idx);
        p11 = p01 + 1;
        v[0] = src_val(p00); v[1] = src_val(p10);
        v[2] = src_val(p01); v[3] = src_val(p11);
        case (e[1:0])
            2'b00: return v[0];
            2'b10: begin
                r = (v[0][15:11] + v[1][15:11]) >> 1;
                g = (v[0][10:5]  + v[1][10:5])  >> 1;
                b = (v[0][4:0]   + v[1][4:0])   >> 1;
            end
            2'b01: begin
                r = (v[0][15:11] + v[2][15:11]) >> 1;
                g = (v[0][10:5]  + v[2][10:5])  >> 1;
                b = (v[0][4:0]   + v[2][4:0])   >> 1;
            end
            default: begin
                r = (v[0][15:11] + v[1][15:11] + v[2][15:11] + v[3][15:11]) >> 2;
                g = (v[0][10:5]  + v[1][10:5]  + v[2][10:5]  + v[3][10:5])  >> 2;
                b = (v[0][4:0]   + v[1][4:0]   + v[2][4:0]   + v[3][4:0])   >> 2;
            end
        endcase
        return {r[4:0], g[5:0], b[4:0]};
    endfunction

    // Runs one frame; bp=1 applies backpressure, scramble=1 changes inputs mid-frame.
    task automatic run_frame(logic [31:0] lb, logic [31:0] eb, logic [31:0] ob,
                             logic [28:0] lw, bit bp, bit scramble);
        logic [15:0] expv [NPIX];
        int got = 0, lut_k = 0, src_n = 0, exp_src = 0, t = 0, dn = 0;
        bit hold = 0;
        logic [15:0] held = '0;
        for (int i = 0; i < NPIX; i++) begin
            expv[i] = exp_pix(lut_mem[i], eb, ob, {3'b000, lw});
            exp_src += nreads(lut_mem[i]);
        end
        @(negedge clk);
        cur_lb = lb; lut_base = lb; even_base = eb; odd_base = ob; line_width = lw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            lut_base = 32'h7777; even_base = 32'h5555; odd_base = 32'h6666; line_width = 29'd3;
        end
        while (got < NPIX && t < 5000) begin
            if (lut_req) begin
                check("R1 lut address", lut_addr, lb + 32'(lut_k));
                lut_k++;
            end
            if (src_req) src_n++;
            if (done) check("R8 early done", 32'(done), 32'd0);
            if (hold) begin
                check("R7 held valid", 32'(pix_valid), 32'd1);
                check("R7 held data", 32'(pix_data), 32'(held));
                hold = 0;
            end
            pix_ready = bp ? ((t % 3) != 1) : 1'b1;
            if (pix_valid && pix_ready) begin
                check({tag_of(lut_mem[got]), " pixel"}, 32'(pix_data), 32'(expv[got]));
                got++;
            end else if (pix_valid) begin
                hold = 1;
                held = pix_data;
            end
            @(negedge clk);
            t++;
        end
        pix_ready = 1'b0;
        check("R1 all pixels delivered", 32'(got), 32'(NPIX));
        for (int k = 0; k < 4; k++) begin
            if (done) dn++;
            @(negedge clk);
        end
        check("R8 single done pulse", 32'(dn), 32'd1);
        check("R1 table reads", 32'(lut_k), 32'(NPIX));
        check("R6 source read count", 32'(src_n), 32'(exp_src));
        check("R8 idle after done", 32'(pix_valid | lut_req | src_req), 32'd0);
    endtask

    task automatic test_reset();
        check("R10 pix_valid", 32'(pix_valid), 32'd0);
        check("R10 done", 32'(done), 32'd0);
        check("R10 lut_req", 32'(lut_req), 32'd0);
        check("R10 src_req", 32'(src_req), 32'd0);
    endtask

    task automatic test_copy();   // R2
        for (int i = 0; i < NPIX; i++) lut_mem[i] = mk(i * 7 + 3, i[0], 0, 0);
        run_frame(32'h100, 32'h1000, 32'h2000, 29'd656, 0, 0);
    endtask

    task automatic test_half_x(); // R3 with R7 backpressure
        for (int i = 0; i < NPIX; i++) lut_mem[i] = mk(i * 11 + 1, i[1], 1, 0);
        run_frame(32'h200, 32'h3000, 32'h4800, 29'd656, 1, 0);
    endtask

    task automatic test_half_y(); // R4 both fields
        for (int i = 0; i < NPIX; i++) lut_mem[i] = mk(i * 5 + 20, i[0], 0, 1);
        run_frame(32'h300, 32'h1000, 32'h2000, 29'd656, 0, 0);
    endtask

    task automatic test_quad();   // R5
        for (int i = 0; i < NPIX; i++) lut_mem[i] = mk(i * 13 + 2, i[0], 1, 1);
        run_frame(32'h400, 32'h0A00, 32'h5100, 29'd100, 1, 0);
    endtask

    task automatic test_invalid(); // R6 mixed with valid words
        for (int i = 0; i < NPIX; i++)
            lut_mem[i] = (i % 3 == 0) ? {INV, i[2:0]} : mk(i, i[0], i[1], i[2]);
        run_frame(32'h500, 32'h1000, 32'h2000, 29'd656, 0, 0);
    endtask

    task automatic test_latch();  // R9 inputs changed after start
        for (int i = 0; i < NPIX; i++) lut_mem[i] = mk(i * 3 + 9, i[1], i[0], i[2]);
        run_frame(32'h600, 32'h1800, 32'h2400, 29'd40, 1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_copy();
        test_half_x();
        test_half_y();
        test_quad();
        test_invalid();
        test_latch();
        report();
        $finish;
    end

endmodule